// File: doc/BRIEF.md
# Audio Codec Receive-Slot Overrun Tracker

This block sits behind the frame decoder of a serial audio codec link. Each time the decoder presents a slot, it gives a valid strobe, the slot number and the sample. The block keeps the sample from the left-channel slot and the sample from the right-channel slot in two holding registers. A data-full flag marks each held sample that has not yet been consumed. A sticky overrun flag records that a new sample arrived before the old one was taken.

Software reads the samples, the status word and the control word through a small word-addressed register port. A DMA engine can take the samples in one of two ways. It can take them one channel at a time, with one request line per channel. It can also take them in packed mode, where both 16-bit samples form one 32-bit word with a single request. The packed mode bit overrides the two per-channel enables.

Top module: `codec_rx_slot_tracker`

## Requirements
- R1: A valid slot with index 3 loads its sample into the left holding register, and index 4 loads the right one. Any other index changes nothing. Register addresses: 0 reads the left sample, 1 reads the right sample, 2 reads status and 3 reads control. Samples read zero-extended to 32 bits.
- R2: A channel's overrun flag sets when a sample for its slot is captured while its data-full flag is set and that flag is not being cleared in the same cycle. A capture in the same cycle as a CPU read of that channel sets no overrun.
- R3: In the status word, bit 13 is the left overrun flag and bit 12 is the right one. Writing 0 to one of these bits clears it, and writing 1 leaves it unchanged. All other status bits read 0 and ignore writes.
- R4: In the control word, bit 31 always reads 1 and bit 30 selects packed mode. Bit 27 is the left DMA enable and bit 26 is the right DMA enable. All other bits read 0 and ignore writes.
- R5: While packed mode is set, the left and right DMA requests stay low whatever the enables hold.
- R6: In packed mode the packed request is high only while both data-full flags are set. The packed word carries the left sample in bits 31:16 and the right sample in bits 15:0. Acknowledging the packed request clears both data-full flags.
- R7: A capture sets the channel's data-full flag. A CPU read of that channel's sample register clears it, and so does an acknowledge of a request that covers the channel. An acknowledge while the matching request is low has no effect.
- R8: If a capture that causes an overrun meets a write of 0 to that overrun bit in the same cycle, the flag ends up set.
- R9: On an overrun, the holding register takes the newer sample.
- R10: Outside packed mode, a channel's DMA request is high exactly when its enable bit and its data-full flag are both set.
- R11: A synchronous active-low reset clears the samples, the flags, packed mode and both enables. After reset the control word reads 0x8000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_vld | input | 1 | Slot sample valid strobe |
| slot_idx | input | SLOT_W | Index of the presented slot |
| slot_data | input | SAMPLE_W | Sample of the presented slot |
| cpu_sel | input | 1 | Register access in this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 2 | Word address of the register |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data for cpu_addr |
| dma_ack_left | input | 1 | Left transfer acknowledge |
| dma_ack_right | input | 1 | Right transfer acknowledge |
| dma_ack_packed | input | 1 | Packed transfer acknowledge |
| dma_req_left | output | 1 | Left-channel DMA request |
| dma_req_right | output | 1 | Right-channel DMA request |
| dma_req_packed | output | 1 | Packed DMA request |
| dma_packed_word | output | 32 | Left and right samples combined |
| full_left | output | 1 | Left data-full flag |
| full_right | output | 1 | Right data-full flag |
| ovf_left | output | 1 | Left overrun flag |
| ovf_right | output | 1 | Right overrun flag |

## Verification
Directed runs cover four cases. Lone captures on each slot and on foreign slots separate correct routing from loads into the wrong channel. Back-to-back captures on one slot separate a correct overrun from a missed one or from keeping the stale sample. Captures that coincide with a read or with a write-0 clear test both same-cycle priority rules. Sequences in packed mode and in per-channel mode check that packing masks the separate enables and waits for both channels. A long stretch of mixed random slots, reads, writes and acknowledges then runs against the behavioural model, which is compared on every clock. It finds any drift in the flag or request logic that the directed cases miss.

// File: rtl/codec_rx_pkg.sv
package codec_rx_pkg;

  localparam int NCH = 2;
  localparam int PACK_W = 16;

  typedef enum logic [1:0] {
    RA_LEFT  = 2'd0,
    RA_RIGHT = 2'd1,
    RA_STAT  = 2'd2,
    RA_CTRL  = 2'd3
  } reg_addr_e;

  localparam int ST_OVF_L_BIT = 13;
  localparam int ST_OVF_R_BIT = 12;
  localparam int CT_ONE_BIT   = 31;
  localparam int CT_PACK_BIT  = 30;
  localparam int CT_EN_L_BIT  = 27;
  localparam int CT_EN_R_BIT  = 26;

  typedef struct packed {
    logic packed16;
    logic en_l;
    logic en_r;
  } rx_ctrl_t;

  function automatic int ovf_bit(int ch);
    return (ch == 0) ? ST_OVF_L_BIT : ST_OVF_R_BIT;
  endfunction

  function automatic logic [31:0] status_image(logic ovl, logic ovr);
    logic [31:0] w;
    w = '0;
    w[ST_OVF_L_BIT] = ovl;
    w[ST_OVF_R_BIT] = ovr;
    return w;
  endfunction

  function automatic logic [31:0] ctrl_image(rx_ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[CT_ONE_BIT]  = 1'b1;
    w[CT_PACK_BIT] = c.packed16;
    w[CT_EN_L_BIT] = c.en_l;
    w[CT_EN_R_BIT] = c.en_r;
    return w;
  endfunction

  function automatic logic [31:0] pack_pair(logic [PACK_W-1:0] l, logic [PACK_W-1:0] r);
    return {l, r};
  endfunction

endpackage

// File: rtl/rx_slot_chan.sv
module rx_slot_chan #(
  parameter int SAMPLE_W = 16,
  parameter int SLOT_W   = 4,
  parameter int MY_SLOT  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slot_vld,
  input  logic [SLOT_W-1:0]   slot_idx,
  input  logic [SAMPLE_W-1:0] slot_data,
  input  logic                take_i,
  input  logic                ovf_wr_i,
  input  logic                ovf_wbit_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                full_o,
  output logic                ovf_o,
  output logic                capture_o,
  output logic                overrun_o
);

  logic [SAMPLE_W-1:0] sample_q;
  logic                full_q;
  logic                ovf_q;
  logic                clr_req;

  assign capture_o = slot_vld && (slot_idx == SLOT_W'(MY_SLOT));
  assign overrun_o = capture_o && full_q && !take_i;
  assign clr_req   = ovf_wr_i && !ovf_wbit_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_q <= '0;
      full_q   <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      if (capture_o) sample_q <= slot_data;
      if (capture_o)   full_q <= 1'b1;
      else if (take_i) full_q <= 1'b0;
      if (overrun_o)    ovf_q <= 1'b1;
      else if (clr_req) ovf_q <= 1'b0;
    end
  end

  assign sample_o = sample_q;
  assign full_o   = full_q;
  assign ovf_o    = ovf_q;

  // R2: overrun event leaves the flag set
  a_r2_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    capture_o && full_o && !take_i |=> ovf_o);
  // R3: without a write-0, the flag is sticky
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o && !(ovf_wr_i && !ovf_wbit_i) |=> ovf_o);
  // R8: set beats a same-cycle clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o && ovf_wr_i && !ovf_wbit_i |=> ovf_o);
  // R7: capture marks the channel full
  a_r7_capture_full: assert property (@(posedge clk) disable iff (!rst_n)
    capture_o |=> full_o);
  // R9: newest sample is the one held
  a_r9_newer_kept: assert property (@(posedge clk) disable iff (!rst_n)
    capture_o |=> sample_o == $past(slot_data));

endmodule

// File: rtl/rx_dma_ctl.sv
module rx_dma_ctl
  import codec_rx_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctrl_wr,
  input  logic           wr_pack,
  input  logic           wr_en_l,
  input  logic           wr_en_r,
  input  logic [NCH-1:0] full,
  input  logic           ack_l,
  input  logic           ack_r,
  input  logic           ack_p,
  output rx_ctrl_t       ctrl_q,
  output logic           req_l,
  output logic           req_r,
  output logic           req_p,
  output logic [NCH-1:0] dma_take
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q.packed16 <= wr_pack;
      ctrl_q.en_l     <= wr_en_l;
      ctrl_q.en_r     <= wr_en_r;
    end
  end

  assign req_l = !ctrl_q.packed16 && ctrl_q.en_l && full[0];
  assign req_r = !ctrl_q.packed16 && ctrl_q.en_r && full[1];
  assign req_p =  ctrl_q.packed16 && (&full);

  assign dma_take[0] = (ack_l && req_l) || (ack_p && req_p);
  assign dma_take[1] = (ack_r && req_r) || (ack_p && req_p);

  // R5: packing mutes the per-channel requests
  a_r5_packed_mutes: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.packed16 |-> !req_l && !req_r);
  // R6: the packed request needs both channels full
  a_r6_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    req_p |-> full[0] && full[1]);
  // R10: per-channel request implies its enable and data
  a_r10_left_gated: assert property (@(posedge clk) disable iff (!rst_n)
    req_l |-> ctrl_q.en_l && full[0]);
  a_r10_right_gated: assert property (@(posedge clk) disable iff (!rst_n)
    req_r |-> ctrl_q.en_r && full[1]);

endmodule

// File: rtl/codec_rx_slot_tracker.sv
module codec_rx_slot_tracker
  import codec_rx_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int SLOT_W     = 4,
  parameter int LEFT_SLOT  = 3,
  parameter int RIGHT_SLOT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slot_vld,
  input  logic [SLOT_W-1:0]   slot_idx,
  input  logic [SAMPLE_W-1:0] slot_data,
  input  logic                cpu_sel,
  input  logic                cpu_we,
  input  logic [1:0]          cpu_addr,
  input  logic [31:0]         cpu_wdata,
  output logic [31:0]         cpu_rdata,
  input  logic                dma_ack_left,
  input  logic                dma_ack_right,
  input  logic                dma_ack_packed,
  output logic                dma_req_left,
  output logic                dma_req_right,
  output logic                dma_req_packed,
  output logic [31:0]         dma_packed_word,
  output logic                full_left,
  output logic                full_right,
  output logic                ovf_left,
  output logic                ovf_right
);

  localparam int TOP_BIT = SAMPLE_W - 1;

  logic                cpu_rd;
  logic                stat_wr;
  logic                ctrl_wr;
  logic [NCH-1:0]      full;
  logic [NCH-1:0]      ovf;
  logic [NCH-1:0]      take;
  logic [NCH-1:0]      dma_take;
  logic [NCH-1:0]      capture;
  logic [NCH-1:0]      overrun;
  logic [SAMPLE_W-1:0] smp [NCH];
  rx_ctrl_t            ctrl_q;
  logic                unused_wbits;

  assign cpu_rd  = cpu_sel && !cpu_we;
  assign stat_wr = cpu_sel &&  cpu_we && (cpu_addr == RA_STAT);
  assign ctrl_wr = cpu_sel &&  cpu_we && (cpu_addr == RA_CTRL);
  assign unused_wbits = ^cpu_wdata;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int CH_SLOT = (g == 0) ? LEFT_SLOT : RIGHT_SLOT;
    localparam int OB      = ovf_bit(g);

    assign take[g] = (cpu_rd && (cpu_addr == 2'(g))) || dma_take[g];

    rx_slot_chan #(
      .SAMPLE_W (SAMPLE_W),
      .SLOT_W   (SLOT_W),
      .MY_SLOT  (CH_SLOT)
    ) i_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_vld   (slot_vld),
      .slot_idx   (slot_idx),
      .slot_data  (slot_data),
      .take_i     (take[g]),
      .ovf_wr_i   (stat_wr),
      .ovf_wbit_i (cpu_wdata[OB]),
      .sample_o   (smp[g]),
      .full_o     (full[g]),
      .ovf_o      (ovf[g]),
      .capture_o  (capture[g]),
      .overrun_o  (overrun[g])
    );
  end

  rx_dma_ctl i_dma (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_wr  (ctrl_wr),
    .wr_pack  (cpu_wdata[CT_PACK_BIT]),
    .wr_en_l  (cpu_wdata[CT_EN_L_BIT]),
    .wr_en_r  (cpu_wdata[CT_EN_R_BIT]),
    .full     (full),
    .ack_l    (dma_ack_left),
    .ack_r    (dma_ack_right),
    .ack_p    (dma_ack_packed),
    .ctrl_q   (ctrl_q),
    .req_l    (dma_req_left),
    .req_r    (dma_req_right),
    .req_p    (dma_req_packed),
    .dma_take (dma_take)
  );

  always_comb begin
    case (cpu_addr)
      RA_LEFT:  cpu_rdata = 32'(smp[0]);
      RA_RIGHT: cpu_rdata = 32'(smp[1]);
      RA_STAT:  cpu_rdata = status_image(ovf[0], ovf[1]);
      default:  cpu_rdata = ctrl_image(ctrl_q);
    endcase
  end

  assign dma_packed_word = pack_pair(smp[0][TOP_BIT -: PACK_W], smp[1][TOP_BIT -: PACK_W]);
  assign full_left  = full[0];
  assign full_right = full[1];
  assign ovf_left   = ovf[0];
  assign ovf_right  = ovf[1];

  // R7: a CPU read of the left sample empties it when no capture competes
  a_r7_read_drains: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && cpu_addr == RA_LEFT && !capture[0] |=> !full_left);
  // R6: a packed acknowledge empties both channels absent new captures
  a_r6_ack_drains: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ack_packed && dma_req_packed && !capture[0] && !capture[1] |=> !full_left && !full_right);
  // R2: a read in the same cycle as a capture blocks the overrun
  a_r2_read_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && cpu_addr == RA_LEFT |-> !overrun[0]);

endmodule

// File: tb/test_codec_rx_slot_tracker.sv
module test_codec_rx_slot_tracker;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        slot_vld;
  logic [3:0]  slot_idx;
  logic [15:0] slot_data;
  logic        cpu_sel, cpu_we;
  logic [1:0]  cpu_addr;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic        dma_ack_left, dma_ack_right, dma_ack_packed;
  logic        dma_req_left, dma_req_right, dma_req_packed;
  logic [31:0] dma_packed_word;
  logic        full_left, full_right, ovf_left, ovf_right;

  always #5 clk = ~clk;

  codec_rx_slot_tracker i_codec_rx_slot_tracker (
    .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_idx(slot_idx),
    .slot_data(slot_data), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .dma_ack_left(dma_ack_left), .dma_ack_right(dma_ack_right),
    .dma_ack_packed(dma_ack_packed), .dma_req_left(dma_req_left),
    .dma_req_right(dma_req_right), .dma_req_packed(dma_req_packed),
    .dma_packed_word(dma_packed_word), .full_left(full_left),
    .full_right(full_right), .ovf_left(ovf_left), .ovf_right(ovf_right)
  );

  // behavioural model state
  logic [15:0] ml, mr;
  logic ml_f, mr_f, ml_o, mr_o, m_pk, m_enl, m_enr;
  int checks = 0, errors = 0;
  bit done = 0;
  string cur_tag = "R1";

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [1:0] a);
    case (a)
      2'd0: return {16'h0, ml};
      2'd1: return {16'h0, mr};
      2'd2: return (32'(ml_o) << 13) | (32'(mr_o) << 12);
      default: return 32'h8000_0000 | (32'(m_pk) << 30) | (32'(m_enl) << 27) | (32'(m_enr) << 26);
    endcase
  endfunction

  task automatic idle();
    slot_vld = 0; slot_idx = 0; slot_data = 0;
    cpu_sel = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
    dma_ack_left = 0; dma_ack_right = 0; dma_ack_packed = 0;
  endtask

  task automatic step();
    logic rql, rqr, rqp, tkl, tkr, cpl, cpr, rd, sw;
    logic nlo, nro;
    #1;
    rql = !m_pk && m_enl && ml_f;
    rqr = !m_pk && m_enr && mr_f;
    rqp = m_pk && ml_f && mr_f;
    if (rst_n) begin
      chk("R10", 32'(dma_req_left), 32'(rql));
      chk("R10", 32'(dma_req_right), 32'(rqr));
      chk("R6", 32'(dma_req_packed), 32'(rqp));
      chk("R6", dma_packed_word, {ml, mr});
      if (cpu_sel && !cpu_we) chk(cur_tag, cpu_rdata, exp_read(cpu_addr));
    end
    rd  = cpu_sel && !cpu_we;
    sw  = cpu_sel && cpu_we && cpu_addr == 2'd2;
    cpl = slot_vld && slot_idx == 4'd3;
    cpr = slot_vld && slot_idx == 4'd4;
    tkl = (rd && cpu_addr == 2'd0) || (dma_ack_left && rql) || (dma_ack_packed && rqp);
    tkr = (rd && cpu_addr == 2'd1) || (dma_ack_right && rqr) || (dma_ack_packed && rqp);
    nlo = (cpl && ml_f && !tkl) ? 1'b1 : (sw && !cpu_wdata[13]) ? 1'b0 : ml_o;
    nro = (cpr && mr_f && !tkr) ? 1'b1 : (sw && !cpu_wdata[12]) ? 1'b0 : mr_o;
    @(posedge clk);
    if (!rst_n) begin
      ml = 0; mr = 0; ml_f = 0; mr_f = 0; ml_o = 0; mr_o = 0;
      m_pk = 0; m_enl = 0; m_enr = 0;
    end else begin
      ml_o = nlo; mr_o = nro;
      if (cpl) ml = slot_data;
      if (cpr) mr = slot_data;
      ml_f = cpl ? 1'b1 : (tkl ? 1'b0 : ml_f);
      mr_f = cpr ? 1'b1 : (tkr ? 1'b0 : mr_f);
      if (cpu_sel && cpu_we && cpu_addr == 2'd3) begin
        m_pk = cpu_wdata[30]; m_enl = cpu_wdata[27]; m_enr = cpu_wdata[26];
      end
    end
    #1;
    chk("R7", 32'(full_left), 32'(ml_f));
    chk("R7", 32'(full_right), 32'(mr_f));
    chk("R2", 32'(ovf_left), 32'(ml_o));
    chk("R2", 32'(ovf_right), 32'(mr_o));
  endtask

  task automatic cap(int s, logic [15:0] d);
    idle(); slot_vld = 1; slot_idx = 4'(s); slot_data = d; step(); idle();
  endtask
  task automatic rd(logic [1:0] a);
    idle(); cpu_sel = 1; cpu_addr = a; step(); idle();
  endtask
  task automatic wr(logic [1:0] a, logic [31:0] d);
    idle(); cpu_sel = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d; step(); idle();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog got hang expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    ml = 0; mr = 0; ml_f = 0; mr_f = 0; ml_o = 0; mr_o = 0;
    m_pk = 0; m_enl = 0; m_enr = 0;
    idle(); rst_n = 0;
    step(); step(); rst_n = 1;

    // R11: state after reset
    cur_tag = "R11";
    rd(2'd3); chk("R11", cpu_rdata, 32'h8000_0000);
    rd(2'd2); rd(2'd0);

    // R1: slot routing and foreign slots
    cur_tag = "R1";
    cap(3, 16'h1234); cap(4, 16'hABCD); cap(5, 16'h5555); cap(0, 16'h7777);
    rd(2'd0); rd(2'd1);
    chk("R1", {31'd0, full_left | full_right}, 32'd0);

    // R2 / R9: back-to-back captures on the left slot
    cur_tag = "R9";
    cap(3, 16'h0A0A); cap(3, 16'h0B0B);
    chk("R2", 32'(ovf_left), 32'd1);
    rd(2'd0);
    cur_tag = "R3";
    rd(2'd2);

    // R3: write 1 keeps, write 0 clears, reserved bits ignore writes
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2);
    chk("R3", cpu_rdata, 32'h0000_2000);
    wr(2'd2, 32'h0000_0000); rd(2'd2);
    chk("R3", cpu_rdata, 32'h0);

    // R8: overrun capture meets a write-0 clear
    cap(3, 16'h1111);
    idle(); slot_vld = 1; slot_idx = 4'd3; slot_data = 16'h2222;
    cpu_sel = 1; cpu_we = 1; cpu_addr = 2'd2; cpu_wdata = 32'h0; step(); idle();
    chk("R8", 32'(ovf_left), 32'd1);
    wr(2'd2, 32'h0);

    // R2: capture in the same cycle as a read sets no overrun
    idle(); slot_vld = 1; slot_idx = 4'd3; slot_data = 16'h3333;
    cpu_sel = 1; cpu_addr = 2'd0; step(); idle();
    chk("R2", {30'd0, ovf_left, full_left}, 32'd1);
    rd(2'd0);

    // R4: control word layout
    cur_tag = "R4";
    wr(2'd3, 32'h4C00_0000); rd(2'd3);
    chk("R4", cpu_rdata, 32'hCC00_0000);
    wr(2'd3, 32'h0000_0000); rd(2'd3);
    chk("R4", cpu_rdata, 32'h8000_0000);

    // R10: per-channel requests
    cur_tag = "R10";
    wr(2'd3, 32'h0800_0000);
    cap(3, 16'h4444); cap(4, 16'h5656);
    chk("R10", {30'd0, dma_req_left, dma_req_right}, 32'd2);
    // R7: ack of an idle request has no effect
    idle(); dma_ack_right = 1; step(); idle();
    chk("R7", 32'(full_right), 32'd1);
    idle(); dma_ack_left = 1; step(); idle();
    chk("R7", 32'(full_left), 32'd0);
    wr(2'd3, 32'h0400_0000); step(); step();
    idle(); dma_ack_right = 1; step(); idle();

    // R5 / R6: packed mode
    cur_tag = "R6";
    wr(2'd3, 32'h4C00_0000);
    cap(3, 16'hBEEF);
    chk("R5", {30'd0, dma_req_left, dma_req_packed}, 32'd0);
    cap(4, 16'hCAFE);
    chk("R6", {31'd0, dma_req_packed}, 32'd1);
    chk("R6", dma_packed_word, 32'hBEEF_CAFE);
    chk("R5", {30'd0, dma_req_left, dma_req_right}, 32'd0);
    idle(); dma_ack_packed = 1; step(); idle();
    chk("R6", {30'd0, full_left, full_right}, 32'd0);

    // mixed random traffic against the model
    cur_tag = "R1";
    for (int i = 0; i < 600; i++) begin
      int u;
      u = int'($urandom % 16);
      idle();
      slot_vld  = (u < 8);
      slot_idx  = 4'($urandom % 6);
      slot_data = 16'($urandom);
      cpu_sel   = ($urandom % 3 == 0);
      cpu_we    = ($urandom % 2 == 0);
      cpu_addr  = 2'($urandom);
      cpu_wdata = $urandom;
      dma_ack_left   = $urandom % 2 == 0;
      dma_ack_right  = $urandom % 2 == 0;
      dma_ack_packed = $urandom % 2 == 0;
      step();
    end
    idle();

    // R11: reset mid-run with data held
    cap(3, 16'h9999); cap(4, 16'h8888);
    rst_n = 0; step(); rst_n = 1;
    cur_tag = "R11";
    rd(2'd3); chk("R11", cpu_rdata, 32'h8000_0000);
    rd(2'd0); chk("R11", cpu_rdata, 32'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule